// File: doc/BRIEF.md
# Supply Supervisor for a Battery-Backed Static Memory

This controller watches a digitised supply voltage, delivered as an unsigned millivolt code with a valid strobe. It decides three things about an attached static memory. The first is whether the memory is fed from the main rail or from a backup cell. The second is whether memory accesses are write-protected. The third is whether the memory pins are isolated, meaning its inputs are ignored and its data outputs are released to high impedance. The analog switch, the cell and the array itself sit outside the block. It only produces the decisions, plus a 3-bit status code.

The block leaves reset in a shipping state. In that state the backup cell stays disconnected so that it does not drain. The cell is armed only once the supply first qualifies above the full-function level, and it then stays armed until the next reset.

Falling and rising transitions use different switch points. The switch to the backup cell happens somewhat below the full-function level. The return to the main rail happens at a lower level. Normal access resumes only once the supply is back above the full-function level. Every threshold crossing must persist for a parameterised number of consecutive valid samples before the state moves, so single-sample glitches are rejected.

Top module: `vcc_supervisor`

## Requirements
- R1: After reset the status is 0 (fresh), the backup select is 0, and the write-protect, input-ignore and output-tristate flags are all 1.
- R2: In the fresh state, DEB consecutive valid samples above FULL_MV (3000) move the status to 1 (normal). After that the status never returns to 0 until the next reset.
- R3: While the status is 0, no supply level selects the backup cell, and the status stays 0, which reports the data as not retained.
- R4: The three protection flags are always equal to each other. They are 0 exactly when the status is 1 and 1 in every other state. The backup select is 1 exactly when the status is 3.
- R5: In the normal state, DEB consecutive valid samples below FULL_MV move the status to 2 (protected, still on the main rail).
- R6: In status 2, DEB consecutive valid samples below SW_DN_MV (2900) move the status to 3 (backup), which selects the backup cell.
- R7: In status 3, DEB consecutive valid samples above SW_UP_MV (2500) move the status to 4 (recovering). The main rail is reselected while protection stays on.
- R8: In status 2 or 4, DEB consecutive valid samples above FULL_MV return the status to 1. In status 4, DEB consecutive valid samples below SW_UP_MV return the status to 3.
- R9: A transition needs DEB consecutive valid samples that agree on the same target. A valid sample pointing elsewhere restarts the run, and a cycle with the valid strobe low neither counts toward the run nor breaks it.
- R10: All comparisons are strict, so a sample exactly equal to a threshold counts as neither above nor below it.
- R11: The status code is 0 fresh, 1 normal, 2 protected on main, 3 backup, 4 recovering, and never takes any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | The supply sample on vcc_mv is valid in this cycle |
| vcc_mv | input | VW (16) | Supply voltage in millivolts, unsigned |
| use_backup | output | 1 | Feed the memory from the backup cell |
| wr_protect | output | 1 | Block all writes to the memory |
| in_ignore | output | 1 | Treat the memory-side inputs as don't-care |
| out_hiz | output | 1 | Request high impedance on the memory data outputs |
| status | output | 3 | State code, as listed in R11 |

## Verification
The directed part of the test works through several supply patterns:
- It holds a low supply in the fresh state, which separates "not yet armed" from a real switchover.
- It walks the supply slowly down and back up through every switch point, with samples sitting exactly on each threshold. This separates strict comparisons from inclusive ones and checks the falling/rising hysteresis.
- It inserts glitch runs one sample short of the debounce length, and gaps with the valid strobe low. These separate a restarted run from a held run.

The random part is a bounded random walk with occasional large jumps and a sparse valid strobe. Its outputs are compared every cycle against a bench model of the state rules.

// File: rtl/vcc_sup_pkg.sv
package vcc_sup_pkg;

   typedef enum logic [2:0] {
      ST_FRESH   = 3'd0,
      ST_NORMAL  = 3'd1,
      ST_PROT    = 3'd2,
      ST_BACKUP  = 3'd3,
      ST_RECOVER = 3'd4
   } sup_state_e;

   localparam int STATUS_W = 3;

endpackage

// File: rtl/vcc_sup_classify.sv
// Maps the current state and one supply sample to the state that sample
// argues for. Comparisons are strict on both sides (R10).
module vcc_sup_classify
   import vcc_sup_pkg::*;
#(
   parameter int VW       = 16,
   parameter int FULL_MV  = 3000,
   parameter int SW_DN_MV = 2900,
   parameter int SW_UP_MV = 2500
) (
   input  sup_state_e      cur,
   input  logic [VW-1:0]   vcc_mv,
   output sup_state_e      cand
);

   localparam logic [VW-1:0] FULL_C = VW'(FULL_MV);
   localparam logic [VW-1:0] DN_C   = VW'(SW_DN_MV);
   localparam logic [VW-1:0] UP_C   = VW'(SW_UP_MV);

   logic above_full, below_full, below_dn, above_up, below_up;

   always_comb begin
      above_full = vcc_mv > FULL_C;
      below_full = vcc_mv < FULL_C;
      below_dn   = vcc_mv < DN_C;
      above_up   = vcc_mv > UP_C;
      below_up   = vcc_mv < UP_C;
   end

   always_comb begin
      cand = cur;
      unique case (cur)
         ST_FRESH:   if (above_full) cand = ST_NORMAL;
         ST_NORMAL:  if (below_full) cand = ST_PROT;
         ST_PROT: begin
            if (below_dn)        cand = ST_BACKUP;
            else if (above_full) cand = ST_NORMAL;
         end
         ST_BACKUP:  if (above_up) cand = ST_RECOVER;
         ST_RECOVER: begin
            if (above_full)    cand = ST_NORMAL;
            else if (below_up) cand = ST_BACKUP;
         end
         default:    cand = ST_FRESH;
      endcase
   end

endmodule

// File: rtl/vcc_sup_qualify.sv
// Debounce: fires once DEB consecutive valid samples agree on the same
// target that differs from the current state (R9).
module vcc_sup_qualify
   import vcc_sup_pkg::*;
#(
   parameter int DEB = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        valid,
   input  sup_state_e  cur,
   input  sup_state_e  cand,
   output logic        fire
);

   generate
      if (DEB <= 1) begin : g_direct
         always_comb fire = valid && (cand != cur);
      end else begin : g_count
         localparam int CW = $clog2(DEB + 1);
         localparam logic [CW-1:0] LAST_STEP = CW'(DEB - 1);

         logic [CW-1:0] cnt;
         sup_state_e    last;
         logic [CW-1:0] run;

         always_comb begin
            run  = (cand == last && cnt != '0) ? cnt : '0;
            fire = valid && (cand != cur) && (run == LAST_STEP);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               last <= ST_FRESH;
            end else if (valid) begin
               last <= cand;
               if (fire || cand == cur) cnt <= '0;
               else                     cnt <= run + CW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vcc_supervisor.sv
module vcc_supervisor
   import vcc_sup_pkg::*;
#(
   parameter int VW       = 16,
   parameter int FULL_MV  = 3000,
   parameter int SW_DN_MV = 2900,
   parameter int SW_UP_MV = 2500,
   parameter int DEB      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sample_valid,
   input  logic [VW-1:0]   vcc_mv,
   output logic            use_backup,
   output logic            wr_protect,
   output logic            in_ignore,
   output logic            out_hiz,
   output logic [2:0]      status
);

   generate
      if (VW < 12 || VW > 32) begin : g_bad_vw
         $fatal(1, "vcc_supervisor: VW out of range");
      end
      if (!(SW_UP_MV < SW_DN_MV && SW_DN_MV <= FULL_MV)) begin : g_bad_thr
         $fatal(1, "vcc_supervisor: thresholds must satisfy UP < DN <= FULL");
      end
      if (FULL_MV >= (1 << VW)) begin : g_bad_range
         $fatal(1, "vcc_supervisor: FULL_MV does not fit in VW bits");
      end
      if (DEB < 1) begin : g_bad_deb
         $fatal(1, "vcc_supervisor: DEB must be at least 1");
      end
   endgenerate

   sup_state_e st, cand;
   logic       fire;

   vcc_sup_classify #(
      .VW(VW), .FULL_MV(FULL_MV), .SW_DN_MV(SW_DN_MV), .SW_UP_MV(SW_UP_MV)
   ) u_cls (
      .cur   (st),
      .vcc_mv(vcc_mv),
      .cand  (cand)
   );

   vcc_sup_qualify #(.DEB(DEB)) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .valid(sample_valid),
      .cur  (st),
      .cand (cand),
      .fire (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= ST_FRESH;
      else if (fire) st <= cand;
   end

   always_comb begin
      status     = st;
      use_backup = (st == ST_BACKUP);
      wr_protect = (st != ST_NORMAL);
      in_ignore  = (st != ST_NORMAL);
      out_hiz    = (st != ST_NORMAL);
   end

endmodule

// File: rtl/vcc_supervisor_chk.sv
module vcc_supervisor_chk #(
   parameter int VW       = 16,
   parameter int FULL_MV  = 3000,
   parameter int SW_UP_MV = 2500
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sample_valid,
   input logic [VW-1:0] vcc_mv,
   input logic          use_backup,
   input logic          wr_protect,
   input logic          in_ignore,
   input logic          out_hiz,
   input logic [2:0]    status
);

   a_r2_armed_stays: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) != 3'd0) |-> (status != 3'd0));

   a_r3_fresh_no_backup: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 3'd0) |-> !use_backup);

   a_r4_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_protect == in_ignore) && (in_ignore == out_hiz)
      && (wr_protect == (status != 3'd1)));

   a_r4_backup_only_in_backup: assert property (@(posedge clk) disable iff (!rst_n)
      use_backup |-> (status == 3'd3));

   a_r5_normal_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 3'd1 && $past(status) != 3'd1)
      |-> ($past(sample_valid) && $past(vcc_mv) > VW'(FULL_MV)));

   a_r7_leave_backup_rising: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) == 3'd3 && status != 3'd3)
      |-> (status == 3'd4 && $past(vcc_mv) > VW'(SW_UP_MV)));

   a_r9_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_valid) |-> $stable(status));

   a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      status <= 3'd4);

endmodule

bind vcc_supervisor vcc_supervisor_chk #(
   .VW(VW), .FULL_MV(FULL_MV), .SW_UP_MV(SW_UP_MV)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_valid(sample_valid),
   .vcc_mv      (vcc_mv),
   .use_backup  (use_backup),
   .wr_protect  (wr_protect),
   .in_ignore   (in_ignore),
   .out_hiz     (out_hiz),
   .status      (status)
);

// File: tb/vcc_supervisor_tb.sv
`timescale 1ns/1ps
module vcc_supervisor_tb;

   localparam int VW = 16, FULL = 3000, DN = 2900, UP = 2500, DEB = 3;

   logic clk = 1'b0, rst_n = 1'b0, sample_valid = 1'b0;
   logic [VW-1:0] vcc_mv = '0;
   logic use_backup, wr_protect, in_ignore, out_hiz;
   logic [2:0] status;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   // model state
   int m_st = 0, m_cnt = 0, m_last = 0;

   always #2.5 clk = ~clk;

   vcc_supervisor #(.VW(VW), .FULL_MV(FULL), .SW_DN_MV(DN), .SW_UP_MV(UP), .DEB(DEB)) u_dut (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .vcc_mv(vcc_mv),
      .use_backup(use_backup), .wr_protect(wr_protect), .in_ignore(in_ignore),
      .out_hiz(out_hiz), .status(status)
   );

   function automatic int target(int s, int v);
      case (s)
         0: return (v > FULL) ? 1 : 0;
         1: return (v < FULL) ? 2 : 1;
         2: return (v < DN) ? 3 : ((v > FULL) ? 1 : 2);
         3: return (v > UP) ? 4 : 3;
         default: return (v > FULL) ? 1 : ((v < UP) ? 3 : 4);
      endcase
   endfunction

   task automatic model_step(bit vld, int v);
      int t, run;
      if (!vld) return;
      t   = target(m_st, v);
      run = (t == m_last && m_cnt != 0) ? m_cnt : 0;
      m_last = t;
      if (t == m_st) m_cnt = 0;
      else if (run + 1 == DEB) begin m_st = t; m_cnt = 0; end
      else m_cnt = run + 1;
   endtask

   task automatic check(string req, int act, int exp, string what);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(string req);
      check(req, status, m_st, "status");
      check(req, use_backup, (m_st == 3) ? 1 : 0, "use_backup");
      check(req, wr_protect, (m_st != 1) ? 1 : 0, "wr_protect");
      check(req, in_ignore, (m_st != 1) ? 1 : 0, "in_ignore");
      check(req, out_hiz, (m_st != 1) ? 1 : 0, "out_hiz");
   endtask

   // drive at negedge, model and compare after posedge
   task automatic feed(bit vld, int v, int n, string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_valid = vld;
         vcc_mv = VW'(v);
         @(posedge clk);
         #1;
         model_step(vld, v);
         check_outputs(req);
      end
   endtask

   initial begin
      int v;
      void'($urandom(32'd20250611));
      repeat (3) @(posedge clk);
      #1;
      check("R1", status, 0, "reset status");
      check("R1", use_backup, 0, "reset use_backup");
      check("R1", wr_protect & in_ignore & out_hiz, 1, "reset protection flags");
      @(negedge clk) rst_n = 1'b1;

      // R3: low supply in fresh state never selects backup
      feed(1, 2000, 6, "R3");
      check("R3", status, 0, "fresh after drop");
      // R9: invalid gap does not break the arming run
      feed(1, 3100, 2, "R9");
      check("R9", status, 0, "two samples not enough");
      feed(0, 1000, 2, "R9");
      feed(1, 3100, 1, "R2");
      check("R2", status, 1, "armed after third valid sample");
      check("R4", wr_protect, 0, "normal unprotected");
      // R10: equal to FULL is not below
      feed(1, 3000, 5, "R10");
      check("R10", status, 1, "exact full level");
      feed(1, 2950, 3, "R5");
      check("R5", status, 2, "protected on main");
      check("R5", use_backup, 0, "still main rail");
      feed(1, 2900, 4, "R10");
      check("R10", status, 2, "exact switch-down level");
      // R9: glitch restarts run
      feed(1, 2800, 2, "R9");
      feed(1, 2950, 1, "R9");
      feed(1, 2800, 2, "R9");
      check("R9", status, 2, "restarted run");
      feed(1, 2800, 1, "R6");
      check("R6", status, 3, "backup entered");
      check("R6", use_backup, 1, "backup selected");
      feed(1, 2500, 4, "R10");
      check("R10", status, 3, "exact switch-up level");
      feed(1, 2600, 3, "R7");
      check("R7", status, 4, "recovering");
      check("R7", wr_protect, 1, "still protected");
      feed(1, 2400, 3, "R8");
      check("R8", status, 3, "back to backup");
      feed(1, 2600, 3, "R7");
      feed(1, 3100, 3, "R8");
      check("R8", status, 1, "normal again");
      feed(1, 1000, 6, "R2");
      check("R2", status, 3, "armed: backup on drop");
      feed(1, 3100, 3, "R8");
      check("R11", status, 4, "recover code");
      feed(1, 3100, 3, "R8");

      // random walk against the model
      v = 3100;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 49) == 0) v = int'($urandom_range(1800, 3500));
         else v = v + int'($urandom_range(0, 120)) - 60;
         if (v < 1800) v = 1800;
         if (v > 3500) v = 3500;
         feed(($urandom_range(0, 3) != 0), v, 1, "R9");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule